// File: doc/BRIEF.md
# Critical Load Path Stall Tracker

This block is a per-core monitor that estimates, cycle by cycle, the length of the longest chain of dependent load latencies seen during a sampling interval. It also counts the cycles in which the core was stalled on loads and, separately, the cycles in which it was stalled on stores. A performance model reads the three values at the end of an interval and uses them to predict how run time scales with core frequency.

The core reports four kinds of events as single-cycle strobes. A load miss claims a miss-tracking slot. A load stall or a store stall marks a stalled cycle. A load return names its slot and the latency it measured, and several returns may arrive in the same cycle. Each slot keeps a timestamp. When a load claims the slot, the timestamp takes the current critical-path value. When the load returns, the critical path is raised to the timestamp plus the latency, unless the critical path is already larger. A synchronous clear starts a new interval.

Top module: `crit_path_tracker`

## Requirements
- R1: After reset, and in the cycle after `clearIn` is high, all three counters read zero. Every other event presented in a clear cycle is ignored.
- R2: When `allocValid` is high in a cycle, the slot `allocIdx` stores the critical-path value that `lcpCount` shows in that cycle. Any critical-path change made in the same cycle is not captured.
- R3: Each cycle with `loadStall` high adds one to `loadStallCount` and one to `lcpCount`.
- R4: Each cycle with `storeStall` high adds one to `storeStallCount`. It leaves `lcpCount` and `loadStallCount` unchanged.
- R5: A return on port p (bit p of `retValid`, slot in bits p*IDX_W upward of `retIdx`, latency in bits p*LAT_W upward of `retLat`) sets `lcpCount` to the larger of its current value and the slot timestamp plus the latency. `lcpCount` never decreases except on a clear.
- R6: When a load stall and a return fall in the same cycle, the new `lcpCount` is the larger of `lcpCount`+1 and the timestamp plus the latency.
- R7: Returns on several ports in the same cycle are combined by a single maximum. The result does not depend on which port carries which return.
- R8: Every counter saturates at all ones (2^CNT_W-1) and does not wrap. A timestamp-plus-latency sum that exceeds that value counts as all ones.
- R9: A clear also sets every slot timestamp to zero. A return to a slot that has not been claimed since the clear uses a timestamp of zero.
- R10: A cycle with both `loadStall` and `storeStall` high increments both stall counters and `lcpCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clearIn | input | 1 | Synchronous clear at the start of an interval |
| allocValid | input | 1 | A load miss claims a slot this cycle |
| allocIdx | input | IDX_W | Slot claimed by the miss |
| loadStall | input | 1 | Core stalled on a load this cycle |
| storeStall | input | 1 | Core stalled on a store this cycle |
| retValid | input | RET_PORTS | One bit per return port, high when a load returns on it |
| retIdx | input | RET_PORTS*IDX_W | Slot of each returning load |
| retLat | input | RET_PORTS*LAT_W | Measured latency of each returning load |
| lcpCount | output | CNT_W | Critical-path estimate |
| loadStallCount | output | CNT_W | Load-stall cycle count |
| storeStallCount | output | CNT_W | Store-stall cycle count |

## Verification
A vector table replays a chain of four dependent loads, mixed with stalls, until the critical path reaches 21 with 4 load stalls and 1 store stall. This shows that the timestamp captures the value before the update and that the maximum is taken rather than a sum. Directed patterns follow. Two simultaneous returns are presented, then the same returns with the ports swapped, to show that the result does not depend on port order. A stall that coincides with a dominant return separates the maximum rule from adding both. A store stall on its own shows that the other counters are left alone. Events presented during a clear, and a return to a slot whose timestamp was wiped by a clear, separate a real clear from one that only resets the counters. Long runs of stalls and an oversized latency show saturation against wrap-around.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  // Strobes sent from the event control to the datapath each cycle.
  typedef struct packed {
    logic clr;        // wipe counters and timestamps
    logic bumpLoad;   // load-stall cycle: +1 on load count and path
    logic bumpStore;  // store-stall cycle: +1 on store count
  } cpt_strobe_t;

endpackage

// File: rtl/cpt_ctrl.sv
module cpt_ctrl #(
  parameter int NUM_MSHR  = 8,
  parameter int RET_PORTS = 2,
  parameter int IDX_W     = 3
) (
  input  logic                          clearIn,
  input  logic                          loadStall,
  input  logic                          storeStall,
  input  logic                          allocValid,
  input  logic [IDX_W-1:0]              allocIdx,
  input  logic [RET_PORTS-1:0]          retValid,
  input  logic [RET_PORTS*IDX_W-1:0]    retIdx,
  output cpt_pkg::cpt_strobe_t          strobe,
  output logic [NUM_MSHR-1:0]           allocWe,
  output logic [RET_PORTS-1:0]          retEn
);

  // Clear has priority: every other event in a clear cycle is dropped.
  always_comb begin
    strobe.clr       = clearIn;
    strobe.bumpLoad  = loadStall  & ~clearIn;
    strobe.bumpStore = storeStall & ~clearIn;
  end

  // One write enable per slot, decoded from the claimed index.
  always_comb begin
    for (int e = 0; e < NUM_MSHR; e++) begin
      allocWe[e] = allocValid & ~clearIn & (allocIdx == IDX_W'(e));
    end
  end

  // A return counts only when its slot index names a real slot.
  for (genvar p = 0; p < RET_PORTS; p++) begin : g_ret
    logic [IDX_W:0] idxWide;
    assign idxWide  = {1'b0, retIdx[p*IDX_W +: IDX_W]};
    assign retEn[p] = retValid[p] & ~clearIn & (idxWide < (IDX_W+1)'(NUM_MSHR));
  end

endmodule

// File: rtl/cpt_sat_counter.sv
module cpt_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cpt_max_tree.sv
module cpt_max_tree #(
  parameter int N = 2,
  parameter int W = 32
) (
  input  logic [N*W-1:0] vals,
  output logic [W-1:0]   maxVal
);

  // Pairwise reduction by levels; odd leftovers pass through.
  localparam int LEVELS = (N > 1) ? $clog2(N) : 1;
  localparam int SLOTS  = 1 << LEVELS;

  logic [W-1:0] stage [LEVELS+1][SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_leaf
    if (s < N) begin : g_real
      assign stage[0][s] = vals[s*W +: W];
    end else begin : g_pad
      assign stage[0][s] = '0;
    end
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    for (genvar s = 0; s < SLOTS; s++) begin : g_node
      if (s < (SLOTS >> (l + 1))) begin : g_cmp
        assign stage[l+1][s] = (stage[l][2*s] > stage[l][2*s+1]) ?
                               stage[l][2*s] : stage[l][2*s+1];
      end else begin : g_zero
        assign stage[l+1][s] = '0;
      end
    end
  end

  assign maxVal = stage[LEVELS][0];

endmodule

// File: rtl/cpt_datapath.sv
module cpt_datapath #(
  parameter int NUM_MSHR  = 8,
  parameter int RET_PORTS = 2,
  parameter int IDX_W     = 3,
  parameter int LAT_W     = 16,
  parameter int CNT_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cpt_pkg::cpt_strobe_t       strobe,
  input  logic [NUM_MSHR-1:0]        allocWe,
  input  logic [RET_PORTS-1:0]       retEn,
  input  logic [RET_PORTS*IDX_W-1:0] retIdx,
  input  logic [RET_PORTS*LAT_W-1:0] retLat,
  output logic [CNT_W-1:0]           lcpCount,
  output logic [CNT_W-1:0]           loadStallCount,
  output logic [CNT_W-1:0]           storeStallCount
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam int PAD_W = CNT_W + 1 - LAT_W;

  logic [CNT_W-1:0] lcpQ;
  logic [CNT_W-1:0] tsQ [NUM_MSHR];
  logic [RET_PORTS*CNT_W-1:0] candFlat;
  logic [CNT_W-1:0] candMax;
  logic [CNT_W-1:0] lcpBase;
  logic [CNT_W-1:0] lcpNext;

  // Per-slot timestamp: takes the path value seen in the claim cycle.
  for (genvar g = 0; g < NUM_MSHR; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           tsQ[g] <= '0;
      else if (strobe.clr) tsQ[g] <= '0;
      else if (allocWe[g]) tsQ[g] <= lcpQ;
    end

    // A stored timestamp never runs ahead of the path it was taken from.
    p_ts_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
      tsQ[g] <= lcpQ);
  end

  // Completion value of each return, clipped at the counter ceiling.
  for (genvar p = 0; p < RET_PORTS; p++) begin : g_cand
    logic [IDX_W-1:0] slot;
    logic [CNT_W:0]   sum;
    assign slot = retIdx[p*IDX_W +: IDX_W];
    assign sum  = {1'b0, tsQ[slot]} + {{PAD_W{1'b0}}, retLat[p*LAT_W +: LAT_W]};
    assign candFlat[p*CNT_W +: CNT_W] =
      !retEn[p]    ? '0  :
      sum[CNT_W]   ? TOP : sum[CNT_W-1:0];
  end

  cpt_max_tree #(.N(RET_PORTS), .W(CNT_W)) u_max (
    .vals   (candFlat),
    .maxVal (candMax)
  );

  // Stall increment and return completions meet in one comparison.
  always_comb begin
    lcpBase = lcpQ;
    if (strobe.bumpLoad && lcpQ != TOP) lcpBase = lcpQ + 1'b1;
    lcpNext = (candMax > lcpBase) ? candMax : lcpBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lcpQ <= '0;
    else if (strobe.clr) lcpQ <= '0;
    else                 lcpQ <= lcpNext;
  end

  cpt_sat_counter #(.W(CNT_W)) u_loadCnt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobe.clr),
    .inc  (strobe.bumpLoad),
    .cnt  (loadStallCount)
  );

  cpt_sat_counter #(.W(CNT_W)) u_storeCnt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobe.clr),
    .inc  (strobe.bumpStore),
    .cnt  (storeStallCount)
  );

  assign lcpCount = lcpQ;

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (lcpQ == '0 && loadStallCount == '0 && storeStallCount == '0));

  p_load_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bumpLoad && lcpQ != TOP) |=> lcpQ > $past(lcpQ));

  p_load_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.bumpLoad && !strobe.clr) |=> $stable(loadStallCount));

  p_store_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bumpStore && storeStallCount != TOP) |=>
      storeStallCount == $past(storeStallCount) + 1'b1);

  p_lcp_monotone_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clr |=> lcpQ >= $past(lcpQ));

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loadStallCount == TOP && !strobe.clr) |=> loadStallCount == TOP);

endmodule

// File: rtl/crit_path_tracker.sv
module crit_path_tracker #(
  parameter int NUM_MSHR  = 8,
  parameter int RET_PORTS = 2,
  parameter int LAT_W     = 16,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = (NUM_MSHR > 1) ? $clog2(NUM_MSHR) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clearIn,
  input  logic                       allocValid,
  input  logic [IDX_W-1:0]           allocIdx,
  input  logic                       loadStall,
  input  logic                       storeStall,
  input  logic [RET_PORTS-1:0]       retValid,
  input  logic [RET_PORTS*IDX_W-1:0] retIdx,
  input  logic [RET_PORTS*LAT_W-1:0] retLat,
  output logic [CNT_W-1:0]           lcpCount,
  output logic [CNT_W-1:0]           loadStallCount,
  output logic [CNT_W-1:0]           storeStallCount
);

  cpt_pkg::cpt_strobe_t strobe;
  logic [NUM_MSHR-1:0]  allocWe;
  logic [RET_PORTS-1:0] retEn;

  cpt_ctrl #(.NUM_MSHR(NUM_MSHR), .RET_PORTS(RET_PORTS), .IDX_W(IDX_W)) u_ctrl (
    .clearIn    (clearIn),
    .loadStall  (loadStall),
    .storeStall (storeStall),
    .allocValid (allocValid),
    .allocIdx   (allocIdx),
    .retValid   (retValid),
    .retIdx     (retIdx),
    .strobe     (strobe),
    .allocWe    (allocWe),
    .retEn      (retEn)
  );

  cpt_datapath #(
    .NUM_MSHR(NUM_MSHR), .RET_PORTS(RET_PORTS), .IDX_W(IDX_W),
    .LAT_W(LAT_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .allocWe         (allocWe),
    .retEn           (retEn),
    .retIdx          (retIdx),
    .retLat          (retLat),
    .lcpCount        (lcpCount),
    .loadStallCount  (loadStallCount),
    .storeStallCount (storeStallCount)
  );

endmodule

// File: tb/sim_crit_path_tracker.sv
module sim_crit_path_tracker;

  localparam int CW = 12;
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearIn = 1'b0, allocValid = 1'b0, loadStall = 1'b0, storeStall = 1'b0;
  logic [2:0]  allocIdx = '0;
  logic [1:0]  retValid = '0;
  logic [5:0]  retIdx = '0;
  logic [23:0] retLat = '0;
  logic [CW-1:0] lcpCount, loadStallCount, storeStallCount;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  crit_path_tracker #(.NUM_MSHR(8), .RET_PORTS(2), .LAT_W(12), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .allocValid(allocValid),
    .allocIdx(allocIdx), .loadStall(loadStall), .storeStall(storeStall),
    .retValid(retValid), .retIdx(retIdx), .retLat(retLat),
    .lcpCount(lcpCount), .loadStallCount(loadStallCount),
    .storeStallCount(storeStallCount)
  );

  typedef struct packed {
    logic ls; logic ss; logic av; logic [2:0] ai;
    logic r0v; logic [2:0] r0i; logic [11:0] r0l;
    logic r1v; logic [2:0] r1i; logic [11:0] r1l;
    logic [11:0] eLcp; logic [11:0] eLd; logic [11:0] eSt;
  } vec_t;

  // Dependent-load chain: A(0) B(1) C(2) D(3).
  localparam vec_t VEC [8] = '{
    '{1'b0,1'b0,1'b1,3'd0, 1'b0,3'd0,12'd0,  1'b0,3'd0,12'd0,  12'd0, 12'd0,12'd0},
    '{1'b0,1'b0,1'b0,3'd0, 1'b1,3'd0,12'd8,  1'b0,3'd0,12'd0,  12'd8, 12'd0,12'd0},
    '{1'b0,1'b0,1'b1,3'd1, 1'b0,3'd0,12'd0,  1'b0,3'd0,12'd0,  12'd8, 12'd0,12'd0},
    '{1'b1,1'b0,1'b1,3'd2, 1'b0,3'd0,12'd0,  1'b0,3'd0,12'd0,  12'd9, 12'd1,12'd0},
    '{1'b1,1'b0,1'b0,3'd0, 1'b1,3'd1,12'd5,  1'b0,3'd0,12'd0,  12'd13,12'd2,12'd0},
    '{1'b1,1'b1,1'b1,3'd3, 1'b0,3'd0,12'd0,  1'b0,3'd0,12'd0,  12'd14,12'd3,12'd1},
    '{1'b0,1'b0,1'b0,3'd0, 1'b1,3'd3,12'd5,  1'b1,3'd2,12'd12, 12'd20,12'd3,12'd1},
    '{1'b1,1'b0,1'b0,3'd0, 1'b0,3'd0,12'd0,  1'b0,3'd0,12'd0,  12'd21,12'd4,12'd1}
  };

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic clr, input logic ls, input logic ss,
                      input logic av, input logic [2:0] ai,
                      input logic r0v, input logic [2:0] r0i, input logic [11:0] r0l,
                      input logic r1v, input logic [2:0] r1i, input logic [11:0] r1l);
    @(negedge clk);
    clearIn = clr; loadStall = ls; storeStall = ss;
    allocValid = av; allocIdx = ai;
    retValid = {r1v, r0v}; retIdx = {r1i, r0i}; retLat = {r1l, r0l};
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0,0,0, 0,3'd0, 0,3'd0,12'd0, 0,3'd0,12'd0);
  endtask

  task automatic clr();
    step(1,0,0, 0,3'd0, 0,3'd0,12'd0, 0,3'd0,12'd0);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset lcp", lcpCount, 0);
    chk("R1 reset load", loadStallCount, 0);
    chk("R1 reset store", storeStallCount, 0);
    rstN = 1'b1;

    // R2 R3 R4 R5 R6 R7: vector table.
    for (int i = 0; i < 8; i++) begin
      step(0, VEC[i].ls, VEC[i].ss, VEC[i].av, VEC[i].ai,
           VEC[i].r0v, VEC[i].r0i, VEC[i].r0l, VEC[i].r1v, VEC[i].r1i, VEC[i].r1l);
      chk($sformatf("R5 R2 vec%0d lcp", i), lcpCount, VEC[i].eLcp);
      chk($sformatf("R3 vec%0d load", i), loadStallCount, VEC[i].eLd);
      chk($sformatf("R4 vec%0d store", i), storeStallCount, VEC[i].eSt);
    end

    // R4: a store stall alone leaves the path and the load count.
    step(0,0,1, 0,3'd0, 0,3'd0,12'd0, 0,3'd0,12'd0);
    chk("R4 store alone store", storeStallCount, 2);
    chk("R4 store alone lcp", lcpCount, 21);
    chk("R4 store alone load", loadStallCount, 4);

    // R10: both stalls together.
    step(0,1,1, 0,3'd0, 0,3'd0,12'd0, 0,3'd0,12'd0);
    chk("R10 both lcp", lcpCount, 22);
    chk("R10 both load", loadStallCount, 5);
    chk("R10 both store", storeStallCount, 3);

    // R1: events in a clear cycle are dropped.
    step(1,1,1, 1,3'd4, 1,3'd0,12'd50, 0,3'd0,12'd0);
    chk("R1 clear lcp", lcpCount, 0);
    chk("R1 clear load", loadStallCount, 0);
    chk("R1 clear store", storeStallCount, 0);
    idle();
    chk("R1 after clear lcp", lcpCount, 0);

    // R7: two returns, then the same pair on swapped ports.
    for (int sw = 0; sw < 2; sw++) begin
      clr();
      step(0,0,0, 1,3'd4, 0,3'd0,12'd0, 0,3'd0,12'd0);
      for (int k = 0; k < 3; k++) idle();
      step(0,1,0, 0,3'd0, 0,3'd0,12'd0, 0,3'd0,12'd0);
      step(0,1,0, 0,3'd0, 0,3'd0,12'd0, 0,3'd0,12'd0);
      step(0,1,0, 1,3'd5, 0,3'd0,12'd0, 0,3'd0,12'd0);
      chk("R3 pre-return lcp", lcpCount, 3);
      if (sw == 0) step(0,0,0, 0,3'd0, 1,3'd4,12'd10, 1,3'd5,12'd4);
      else         step(0,0,0, 0,3'd0, 1,3'd5,12'd4,  1,3'd4,12'd10);
      chk($sformatf("R7 dual return order%0d", sw), lcpCount, 10);
    end

    // R6: stall with a dominated return, then with a dominant return.
    step(0,1,0, 0,3'd0, 1,3'd5,12'd2, 0,3'd0,12'd0);
    chk("R6 stall wins lcp", lcpCount, 11);
    step(0,1,0, 0,3'd0, 1,3'd4,12'd30, 0,3'd0,12'd0);
    chk("R6 return wins lcp", lcpCount, 30);

    // R9: a clear wipes timestamps.
    step(0,0,0, 1,3'd6, 0,3'd0,12'd0, 0,3'd0,12'd0);
    clr();
    step(0,0,0, 0,3'd0, 1,3'd6,12'd7, 0,3'd0,12'd0);
    chk("R9 cleared timestamp lcp", lcpCount, 7);

    // R8: sum overflow clips to the ceiling.
    clr();
    for (int k = 0; k < 100; k++) step(0,1,0, 0,3'd0, 0,3'd0,12'd0, 0,3'd0,12'd0);
    step(0,0,0, 1,3'd7, 0,3'd0,12'd0, 0,3'd0,12'd0);
    step(0,0,0, 0,3'd0, 1,3'd7,12'd4095, 0,3'd0,12'd0);
    chk("R8 sum saturation lcp", lcpCount, TOP);

    // R8: stall counters saturate.
    clr();
    for (int k = 0; k < 4100; k++) step(0,1,1, 0,3'd0, 0,3'd0,12'd0, 0,3'd0,12'd0);
    chk("R8 load saturation", loadStallCount, TOP);
    chk("R8 store saturation", storeStallCount, TOP);
    chk("R8 lcp saturation", lcpCount, TOP);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule